// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a translation-buffer miss. It receives a 20-bit virtual page number and a flag that says whether the access is a write. It then looks up two levels of page tables in memory and returns either the final page table entry, ready to install in the translation buffer, or a fault code. Each table has 1024 four-byte entries, so every table fills exactly one 4 KB page. The upper ten bits of the page number select the entry in the primary table. The lower ten bits select the entry in the secondary table.

The physical location of the primary table is given by a base input. This is the page table base register of the running process, and its frame field is latched when a walk starts. The primary entry names the frame that holds the secondary table. The secondary entry names the final page frame. The walker checks the valid bit at each level and checks write permission at the leaf. On success it sets the referenced bit, and also the modified bit for a write. The updated entry is written back to memory only when one of those bits actually changes. All memory traffic uses a single 32-bit word port. A request is held until it is granted, and each read then completes with a separate data-valid pulse, however many cycles that takes. Only one walk is in progress at any time.

Top module: `ptw_walker`

## Requirements
- R1: While reset is asserted and after it is released, the walker is idle: req_ready is 1, mem_req is 0 and done is 0.
- R2: The primary read address is {root_base[31:12], req_vpn[19:10], 2'b00}. The secondary read address is {primary_entry[31:12], req_vpn[9:0], 2'b00}. Both are byte addresses of 32-bit words.
- R3: mem_req stays high with a constant mem_addr and mem_we until a cycle with mem_gnt. After a granted read, the walker waits any number of cycles for mem_rvalid and uses mem_rdata only in that cycle.
- R4: If the primary entry has bit 2 (valid) clear, the walk ends with fault code 2'b01 and no further memory access.
- R5: If the secondary entry has bit 2 clear, the walk ends with fault code 2'b10 and no writeback.
- R6: A write to a valid leaf whose bit 4 (write permission) is clear ends with fault code 2'b11 and no writeback. A read of the same leaf succeeds.
- R7: On success, the leaf entry has bit 1 (referenced) set, and bit 0 (modified) also set for a write. That updated entry is written to the secondary entry address (mem_we = 1) only if it differs from the entry that was read.
- R8: done is high for exactly one cycle at the end of every walk. In that cycle fault is 2'b00 and result_pte holds the updated leaf entry on success. On any fault, result_pte is 0.
- R9: A request is accepted only while req_ready is high. A req_valid that arrives during a walk is ignored and never starts a walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Start a walk, taken while req_ready is high |
| req_ready | output | 1 | Walker is idle |
| req_vpn | input | 20 | Virtual page number to translate |
| req_write | input | 1 | Access is a write |
| root_base | input | 32 | Page table base register; bits 31:12 give the primary table frame |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a writeback |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Writeback data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 2 | 00 none, 01 primary invalid, 10 secondary invalid, 11 write protection |
| result_pte | output | 32 | Final leaf entry (frame 31:12, protection 4:3, valid 2, referenced 1, modified 0) |

## Verification
The bench builds the walker with its default parameters: a 32-bit physical address and 12-bit page offset, which give 1024-entry tables and a two-stage reset synchronizer. With these values, the index extremes 0 and 1023 can be reached at both levels, so address packing can be checked at its edges. The bench also changes the grant delay and the read-valid delay from zero up to many cycles, which exercises the hold and wait behaviour of the memory port. Its memory model holds entries with and without referenced, modified, valid and write-permission bits, so that every outcome of the walk and both writeback decisions are covered.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_WB_REQ,
    ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_L1_INV = 2'b01,
    FLT_L2_INV = 2'b10,
    FLT_PROT   = 2'b11
  } walk_fault_e;

  // entry flag positions below the frame field
  localparam int unsigned BIT_MOD   = 0;
  localparam int unsigned BIT_REF   = 1;
  localparam int unsigned BIT_VLD   = 2;
  localparam int unsigned BIT_WPERM = 4;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PA_W     = 32,
  parameter int PG_OFF_W = 12,
  localparam int FRM_W   = PA_W - PG_OFF_W,
  localparam int IDX_W   = PG_OFF_W - 2
) (
  input  logic [FRM_W-1:0]   root_frame_i,
  input  logic [FRM_W-1:0]   next_frame_i,
  input  logic [2*IDX_W-1:0] vpn_i,
  output logic [PA_W-1:0]    l1_addr_o,
  output logic [PA_W-1:0]    l2_addr_o
);
  // table frame, entry index, word alignment
  assign l1_addr_o = {root_frame_i, vpn_i[2*IDX_W-1:IDX_W], 2'b00};
  assign l2_addr_o = {next_frame_i, vpn_i[IDX_W-1:0], 2'b00};
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] entry_i,
  input  logic             is_write_i,
  output logic             present_o,
  output logic             deny_o,
  output logic [PTE_W-1:0] entry_upd_o,
  output logic             wb_o
);
  always_comb begin
    present_o   = entry_i[BIT_VLD];
    deny_o      = is_write_i & ~entry_i[BIT_WPERM];
    entry_upd_o = entry_i;
    entry_upd_o[BIT_REF] = 1'b1;
    if (is_write_i) entry_upd_o[BIT_MOD] = 1'b1;
    wb_o = (entry_upd_o != entry_i);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W       = 32,
  parameter int PG_OFF_W   = 12,
  parameter int RST_STAGES = 2,
  localparam int IDX_W     = PG_OFF_W - 2,
  localparam int VPN_W     = 2 * IDX_W,
  localparam int FRM_W     = PA_W - PG_OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic             req_write,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PA_W-1:0]  mem_wdata,
  input  logic             mem_gnt,
  input  logic             mem_rvalid,
  input  logic [PA_W-1:0]  mem_rdata,
  output logic             done,
  output logic [1:0]       fault,
  output logic [PA_W-1:0]  result_pte
);
  logic        rst_n_int;
  walk_state_e state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  logic             wr_q;
  logic [FRM_W-1:0] root_q;
  logic [FRM_W-1:0] next_q;
  logic [PA_W-1:0]  pte_q, pte_d;
  walk_fault_e      fault_q, fault_d;

  logic [PA_W-1:0] l1_addr, l2_addr, entry_upd;
  logic            present, deny, need_wb;
  logic            cap_en, l1_en, res_en;
  logic            base_low_unused;

  assign base_low_unused = ^root_base[PG_OFF_W-1:0];

  ptw_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_int)
  );

  ptw_addr_gen #(.PA_W(PA_W), .PG_OFF_W(PG_OFF_W)) u_addr_gen (
    .root_frame_i (root_q),
    .next_frame_i (next_q),
    .vpn_i        (vpn_q),
    .l1_addr_o    (l1_addr),
    .l2_addr_o    (l2_addr)
  );

  ptw_pte_check #(.PTE_W(PA_W)) u_pte_check (
    .entry_i     (mem_rdata),
    .is_write_i  (wr_q),
    .present_o   (present),
    .deny_o      (deny),
    .entry_upd_o (entry_upd),
    .wb_o        (need_wb)
  );

  // clock enables
  assign cap_en = (state_q == ST_IDLE) && req_valid;
  assign l1_en  = (state_q == ST_L1_WAIT) && mem_rvalid;
  assign res_en = ((state_q == ST_L1_WAIT) || (state_q == ST_L2_WAIT)) && mem_rvalid;

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_L1_REQ;
      ST_L1_REQ:  if (mem_gnt) state_d = ST_L1_WAIT;
      ST_L1_WAIT: if (mem_rvalid) state_d = present ? ST_L2_REQ : ST_DONE;
      ST_L2_REQ:  if (mem_gnt) state_d = ST_L2_WAIT;
      ST_L2_WAIT: begin
        if (mem_rvalid) begin
          if (!present || deny) state_d = ST_DONE;
          else if (need_wb)     state_d = ST_WB_REQ;
          else                  state_d = ST_DONE;
        end
      end
      ST_WB_REQ:  if (mem_gnt) state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // result decode
  always_comb begin
    pte_d   = '0;
    fault_d = FLT_NONE;
    if (state_q == ST_L1_WAIT) begin
      if (!present) fault_d = FLT_L1_INV;
    end else begin
      if (!present)  fault_d = FLT_L2_INV;
      else if (deny) fault_d = FLT_PROT;
      else           pte_d   = entry_upd;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      vpn_q  <= '0;
      wr_q   <= 1'b0;
      root_q <= '0;
    end else if (cap_en) begin
      vpn_q  <= req_vpn;
      wr_q   <= req_write;
      root_q <= root_base[PA_W-1:PG_OFF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  next_q <= '0;
    else if (l1_en)  next_q <= mem_rdata[PA_W-1:PG_OFF_W];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      pte_q   <= '0;
      fault_q <= FLT_NONE;
    end else if (res_en) begin
      pte_q   <= pte_d;
      fault_q <= fault_d;
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign mem_req    = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ) || (state_q == ST_WB_REQ);
  assign mem_we     = (state_q == ST_WB_REQ);
  assign mem_addr   = (state_q == ST_L1_REQ) ? l1_addr : l2_addr;
  assign mem_wdata  = pte_q;
  assign done       = (state_q == ST_DONE);
  assign fault      = fault_q;
  assign result_pte = pte_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic            mem_gnt,
  input logic [PA_W-1:0] mem_addr,
  input logic [PA_W-1:0] mem_wdata,
  input logic            done,
  input logic [1:0]      fault,
  input logic [PA_W-1:0] result_pte
);
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (req_ready && !mem_req && !done);
    end
  end

  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  p_wb_sets_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[1]);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_zero_pte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done && (fault != 2'b00) |-> (result_pte == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req && !done);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_gnt    (mem_gnt),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .done       (done),
  .fault      (fault),
  .result_pte (result_pte)
);

// File: tb/ptw_walker_tb.sv
module ptw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_vpn = '0;
  logic        req_write = 1'b0;
  logic [31:0] root_base = '0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_gnt = 1'b0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'hDEAD_0000;
  logic        done;
  logic [1:0]  fault;
  logic [31:0] result_pte;

  always #2 clk = ~clk;

  ptw_walker u_dut (.*);

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  logic [31:0] mem_model [int unsigned];
  logic [31:0] q_addr[$];
  logic        q_we[$];
  logic [31:0] q_wd[$];

  int glat = 0;
  int rlat = 0;
  int gcnt = 0;
  logic [31:0] h_addr, h_wd, rd_addr;
  logic        h_we;
  bit          rd_pend = 0;
  int          rd_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [19:0] frm, input logic [1:0] prot,
                                     input bit v, input bit r, input bit m);
    return {frm, 7'd0, prot, v, r, m};
  endfunction

  // memory responder and per-cycle comparison with the expected traffic
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_gnt = 0; mem_rvalid = 0; rd_pend = 0; gcnt = glat;
    end else begin
      mem_rvalid = 1'b0;
      mem_rdata  = 32'hDEAD_0000 | cyc[15:0];
      if (mem_gnt) begin
        mem_gnt = 1'b0;
        gcnt = glat;
        if (h_we) mem_model[h_addr] = h_wd;
        else begin rd_pend = 1; rd_cnt = rlat; rd_addr = h_addr; end
      end else if (mem_req) begin
        if (q_addr.size() == 0) begin
          chk(0, "R9", "unexpected memory request", mem_addr, 32'h0);
        end else begin
          chk(mem_addr == q_addr[0], q_we[0] ? "R7" : "R2", "request address", mem_addr, q_addr[0]);
          chk(mem_we == q_we[0], "R3", "request kind", {31'd0, mem_we}, {31'd0, q_we[0]});
          if (q_we[0]) chk(mem_wdata == q_wd[0], "R7", "writeback data", mem_wdata, q_wd[0]);
          if (gcnt == 0) begin
            mem_gnt = 1'b1;
            h_addr = mem_addr; h_we = mem_we; h_wd = mem_wdata;
            void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_wd.pop_front());
          end else gcnt--;
        end
      end
      if (rd_pend) begin
        if (rd_cnt == 0) begin
          mem_rvalid = 1'b1; mem_rdata = rd(rd_addr); rd_pend = 0;
        end else rd_cnt--;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic walk(input logic [19:0] vpn, input bit wr, input string req, input bit poke);
    logic [31:0] l1a, l2a, e1, e2, upd, ep;
    logic [1:0]  ef;
    bit          wrote;
    int          n;
    wrote = 0; ep = 0; l2a = 0;
    l1a = {root_base[31:12], vpn[19:10], 2'b00};
    e1 = rd(l1a);
    q_addr.push_back(l1a); q_we.push_back(0); q_wd.push_back(0);
    if (!e1[2]) ef = 2'b01;
    else begin
      l2a = {e1[31:12], vpn[9:0], 2'b00};
      e2 = rd(l2a);
      q_addr.push_back(l2a); q_we.push_back(0); q_wd.push_back(0);
      if (!e2[2]) ef = 2'b10;
      else if (wr && !e2[4]) ef = 2'b11;
      else begin
        ef = 2'b00;
        upd = e2 | 32'h2 | (wr ? 32'h1 : 32'h0);
        ep = upd;
        if (upd != e2) begin
          wrote = 1;
          q_addr.push_back(l2a); q_we.push_back(1); q_wd.push_back(upd);
        end
      end
    end
    @(negedge clk);
    chk(req_ready, "R9", "ready before request", {31'd0, req_ready}, 32'h1);
    req_valid = 1; req_vpn = vpn; req_write = wr;
    @(negedge clk);
    req_valid = 0; req_vpn = ~vpn; req_write = ~wr;
    chk(!req_ready, "R9", "busy after accept", {31'd0, req_ready}, 32'h0);
    n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
      if (poke && n == 2) begin req_valid = 1; req_vpn = 20'h3FC01; req_write = 1; end
      if (poke && n == 3) req_valid = 0;
    end
    chk(done, "R8", "done reached", {31'd0, done}, 32'h1);
    chk(fault == ef, req, "fault code", {30'd0, fault}, {30'd0, ef});
    chk(result_pte == ep, req, "result entry", result_pte, ep);
    chk(q_addr.size() == 0, req, "traffic left over", q_addr.size(), 0);
    @(negedge clk);
    chk(!done, "R8", "done single cycle", {31'd0, done}, 32'h0);
    chk(req_ready, "R9", "idle after walk", {31'd0, req_ready}, 32'h1);
    if (wrote) chk(rd(l2a) == ep, "R7", "entry in memory", rd(l2a), ep);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    // tables under base frame 0x00010
    mem_model[{20'h00010, 10'h001, 2'b00}] = mk(20'h00020, 2'b00, 1, 0, 0);
    mem_model[{20'h00020, 10'h005, 2'b00}] = mk(20'hABCDE, 2'b11, 1, 0, 0);
    mem_model[{20'h00020, 10'h006, 2'b00}] = mk(20'h12345, 2'b01, 1, 1, 0);
    mem_model[{20'h00020, 10'h007, 2'b00}] = mk(20'h77777, 2'b11, 0, 1, 1);
    mem_model[{20'h00010, 10'h002, 2'b00}] = mk(20'h00099, 2'b11, 0, 0, 0);
    mem_model[{20'h00010, 10'h3FF, 2'b00}] = mk(20'h00030, 2'b00, 1, 0, 0);
    mem_model[{20'h00030, 10'h3FF, 2'b00}] = mk(20'hFFFFF, 2'b10, 1, 0, 0);
    // tables under base frame 0x00040
    mem_model[{20'h00040, 10'h000, 2'b00}] = mk(20'h00050, 2'b00, 1, 0, 0);
    mem_model[{20'h00050, 10'h000, 2'b00}] = mk(20'h00001, 2'b11, 1, 0, 0);

    #1 rst_n = 0;
    repeat (3) @(negedge clk);
    chk(req_ready && !mem_req && !done, "R1", "idle in reset",
        {29'd0, req_ready, mem_req, done}, 32'h4);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(req_ready && !mem_req && !done, "R1", "idle after reset",
        {29'd0, req_ready, mem_req, done}, 32'h4);

    root_base = 32'h0001_0ABC;  // low bits ignored
    walk({10'h001, 10'h005}, 0, "R7", 0);  // read, referenced set, writeback
    walk({10'h001, 10'h005}, 0, "R7", 0);  // read again, nothing to write
    glat = 3; rlat = 7;
    walk({10'h001, 10'h005}, 1, "R7", 0);  // write, modified set
    walk({10'h001, 10'h005}, 1, "R7", 0);  // write again, no writeback
    glat = 0; rlat = 15;
    walk({10'h001, 10'h006}, 1, "R6", 0);  // write to read-only leaf
    walk({10'h001, 10'h006}, 0, "R6", 0);  // read of read-only leaf
    glat = 5; rlat = 0;
    walk({10'h002, 10'h123}, 0, "R4", 0);  // primary invalid
    walk({10'h001, 10'h007}, 1, "R5", 0);  // secondary invalid
    glat = 2; rlat = 20;
    walk({10'h3FF, 10'h3FF}, 0, "R2", 0);  // top index at both levels
    walk({10'h001, 10'h006}, 0, "R9", 1);  // request during walk ignored
    glat = 1; rlat = 3;
    root_base = 32'h0004_0000;
    walk(20'h00000, 1, "R2", 0);           // index zero, new base, R and M set
    repeat (6) @(negedge clk);
    chk(!mem_req && req_ready, "R9", "no stray walk", {30'd0, mem_req, req_ready}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule